// File: doc/BRIEF.md
# Sector/Track Transfer Address Sequencer

This block steers word transfers between a data channel and a fixed-geometry disk. Each sector holds 128 words, each track holds 64 sectors, and the disk has 32 tracks. Software loads a desired-address register, in which the sector is in bits 5:0 and the track in bits 11:6. It then starts a read, a write or a search. The sequencer checks the address at the first word of every sector. For each word moved, it presents a word address: the linear block number (track × 64 + sector) times 128, plus the word index. The storage that sits behind this address is outside the block.

Words move on a valid/ready handshake with the channel. The channel marks its final word with a last flag. When a sector fills, the address steps to the next sector. Past sector 63 it wraps to sector 0 of the next track. Stepping past the final track raises a last-sector flag. On a write that the channel ends early, the block fills the rest of the sector with zero words itself. The address then stays where it is.

Top module: `xfer_addr_seq`

## Requirements
- R1: The address register keeps the sector in bits 5:0 and the track in bits 11:6. Bits 15:12 of the readback are always 0. After reset the register holds 0.
- R2: A load of the address register is ignored while the block is busy.
- R3: During a transfer, each word strobe carries word address ((track × 64) + sector) × 128 + word index. The `lba_o` port shows track × 64 + sector.
- R4: At word 0 of a sector, a track ≥ 32 (or a sector ≥ 64) aborts the operation. `iae_o`, `err_o` and `attn_o` are set and busy clears. No word moves, `chan_ready_o` stays low and `done_o` is not pulsed.
- R5: After word 127 of a sector moves, the sector increments. At 64 the sector returns to 0 and the track increments. The word index restarts at 0.
- R6: When the track reaches 32 through that increment, `last_sect_o` is set.
- R7: A write whose last channel word comes before word 127 pads the sector. The block drives one zero-data strobe per cycle, with `word_we_o` high, up to word 127. It then finishes without advancing the address. Write words from the channel pass through unchanged.
- R8: A read whose last channel word comes before word 127 finishes without advancing the address.
- R9: A search checks the address, sets `attn_o`, and sets `iae_o` and `err_o` only if the address is out of range. It moves no words and does not pulse `done_o`.
- R10: `done_o` pulses for one cycle in the cycle after a transfer completes, and `busy_o` is low in that same cycle.
- R11: Operation codes are 0 read, 1 write, 2 search and 3 reserved. A start with code 3 is ignored. Any other start clears `iae_o`, `err_o`, `attn_o` and `last_sect_o` and resets the word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| da_we_i | input | 1 | Load the desired-address register |
| da_wdata_i | input | 12 | Track (11:6) and sector (5:0) to load |
| da_o | output | 16 | Desired-address readback |
| start_i | input | 1 | Start an operation |
| op_i | input | 2 | Operation code (R11) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| attn_o | output | 1 | Attention flag |
| err_o | output | 1 | Error flag |
| iae_o | output | 1 | Invalid-address flag |
| last_sect_o | output | 1 | Stepped past the final track |
| chan_valid_i | input | 1 | Channel offers or accepts a word |
| chan_last_i | input | 1 | Channel's final word |
| chan_data_i | input | 36 | Write data from channel |
| chan_ready_o | output | 1 | Sequencer accepts a word this cycle |
| word_stb_o | output | 1 | A word moves this cycle |
| word_we_o | output | 1 | The moving word is a write |
| word_addr_o | output | 18 | Word address of the moving word |
| word_data_o | output | 36 | Write data, zero while padding |
| lba_o | output | 11 | Linear block address |

## Verification
The handshake outputs `chan_ready_o`, `word_stb_o`, `word_addr_o` and `word_data_o` are combinational, so they are checked 1 ns after the bench drives the channel inputs, in the same cycle. Status is registered:
- `busy_o` is due after the edge that samples `start_i`.
- The abort and search flags are due one edge later.
- `done_o`, the stepped address and `last_sect_o` are due on the edge that takes the final word, or the final pad word.

Inputs change on the falling edge and outputs are sampled on the falling edge, so every check lands a half period after the edge it depends on.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  localparam int FLD_W  = 6;
  localparam int DA_W   = 16;
  localparam int DATA_W = 36;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_SEARCH = 2'd2,
    OP_RSVD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_PAD,
    ST_SRCH
  } st_e;
endpackage

// File: rtl/xfer_word_ctr.sv
module xfer_word_ctr #(
  parameter int WPS = 128,
  localparam int CW = $clog2(WPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          end_o
);
  assign end_o = (cnt_o == CW'(WPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= end_o ? '0 : cnt_o + 1'b1;
  end

  p_cnt_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && end_o && !clr_i) |=> (cnt_o == '0));
endmodule

// File: rtl/xfer_addr_reg.sv
module xfer_addr_reg
  import xfer_seq_pkg::*;
#(
  parameter int SECTS = 64,
  parameter int TRACKS = 32,
  localparam int LBA_W = $clog2(SECTS * TRACKS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [2*FLD_W-1:0] load_val_i,
  input  logic               adv_i,
  output logic [DA_W-1:0]    da_o,
  output logic [LBA_W-1:0]   lba_o,
  output logic               ok_o,
  output logic               wrap_o
);
  logic [FLD_W-1:0] sect_q, trk_q;

  assign ok_o   = (int'(sect_q) < SECTS) && (int'(trk_q) < TRACKS);
  assign lba_o  = LBA_W'(int'(trk_q) * SECTS + int'(sect_q));
  assign da_o   = {{(DA_W - 2*FLD_W){1'b0}}, trk_q, sect_q};
  assign wrap_o = adv_i && (int'(sect_q) == SECTS - 1) && (int'(trk_q) == TRACKS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sect_q <= '0;
      trk_q  <= '0;
    end else if (load_i) begin
      sect_q <= load_val_i[FLD_W-1:0];
      trk_q  <= load_val_i[2*FLD_W-1:FLD_W];
    end else if (adv_i) begin
      if (int'(sect_q) == SECTS - 1) begin
        sect_q <= '0;
        trk_q  <= trk_q + 1'b1;
      end else begin
        sect_q <= sect_q + 1'b1;
      end
    end
  end

  p_sect_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && int'(sect_q) == SECTS - 1) |=>
      (sect_q == '0 && trk_q == $past(trk_q) + 1'b1));
endmodule

// File: rtl/xfer_addr_seq.sv
module xfer_addr_seq
  import xfer_seq_pkg::*;
#(
  parameter int WPS = 128,
  parameter int SECTS = 64,
  parameter int TRACKS = 32,
  localparam int CW = $clog2(WPS),
  localparam int LBA_W = $clog2(SECTS * TRACKS),
  localparam int AW = $clog2(WPS * SECTS * TRACKS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               da_we_i,
  input  logic [2*FLD_W-1:0] da_wdata_i,
  output logic [DA_W-1:0]    da_o,
  input  logic               start_i,
  input  logic [1:0]         op_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               attn_o,
  output logic               err_o,
  output logic               iae_o,
  output logic               last_sect_o,
  input  logic               chan_valid_i,
  input  logic               chan_last_i,
  input  logic [DATA_W-1:0]  chan_data_i,
  output logic               chan_ready_o,
  output logic               word_stb_o,
  output logic               word_we_o,
  output logic [AW-1:0]      word_addr_o,
  output logic [DATA_W-1:0]  word_data_o,
  output logic [LBA_W-1:0]   lba_o
);
  st_e st_q;
  logic is_wr_q;
  logic addr_ok, wrap, adv, fire, abort, start_ok, cnt_end;
  logic [CW-1:0] cnt;

  assign start_ok     = start_i && (st_q == ST_IDLE) && (op_e'(op_i) != OP_RSVD);
  assign chan_ready_o = (st_q == ST_XFER) && ((cnt != '0) || addr_ok);
  assign abort        = (st_q == ST_XFER) && (cnt == '0) && !addr_ok;
  assign fire         = chan_valid_i && chan_ready_o;
  assign adv          = fire && cnt_end;
  assign word_stb_o   = fire || (st_q == ST_PAD);
  assign word_we_o    = word_stb_o && is_wr_q;
  assign word_data_o  = (st_q == ST_XFER && is_wr_q) ? chan_data_i : '0;
  assign word_addr_o  = AW'(int'(lba_o) * WPS + int'(cnt));
  assign busy_o       = (st_q != ST_IDLE);

  xfer_addr_reg #(.SECTS(SECTS), .TRACKS(TRACKS)) u_addr (
    .clk_i, .rst_ni,
    .load_i     (da_we_i && st_q == ST_IDLE),
    .load_val_i (da_wdata_i),
    .adv_i      (adv),
    .da_o, .lba_o,
    .ok_o       (addr_ok),
    .wrap_o     (wrap)
  );

  xfer_word_ctr #(.WPS(WPS)) u_ctr (
    .clk_i, .rst_ni,
    .clr_i (start_ok),
    .inc_i (word_stb_o),
    .cnt_o (cnt),
    .end_o (cnt_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      is_wr_q     <= 1'b0;
      done_o      <= 1'b0;
      attn_o      <= 1'b0;
      err_o       <= 1'b0;
      iae_o       <= 1'b0;
      last_sect_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (wrap) last_sect_o <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (start_ok) begin
          attn_o      <= 1'b0;
          err_o       <= 1'b0;
          iae_o       <= 1'b0;
          last_sect_o <= 1'b0;
          is_wr_q     <= (op_e'(op_i) == OP_WRITE);
          st_q        <= (op_e'(op_i) == OP_SEARCH) ? ST_SRCH : ST_XFER;
        end
        ST_XFER: begin
          if (abort) begin
            iae_o  <= 1'b1;
            err_o  <= 1'b1;
            attn_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (fire && chan_last_i) begin
            if (cnt_end || !is_wr_q) begin
              done_o <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_PAD;
            end
          end
        end
        ST_PAD: if (cnt_end) begin
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_SRCH: begin
          attn_o <= 1'b1;
          if (!addr_ok) begin
            iae_o <= 1'b1;
            err_o <= 1'b1;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_abort_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iae_o) |-> (err_o && attn_o && !busy_o && !done_o));
  p_stb_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |-> addr_ok);
  p_last_track_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(last_sect_o) |-> (da_o[2*FLD_W-1:FLD_W] == FLD_W'(TRACKS) && da_o[FLD_W-1:0] == '0));
  p_pad_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb_o && !chan_ready_o) |-> (word_data_o == '0 && word_we_o));
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/xfer_addr_seq_tb.sv
module xfer_addr_seq_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        da_we = 1'b0;
  logic [11:0] da_wdata = '0;
  logic [15:0] da;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic        busy, done, attn, err, iae, last_sect;
  logic        chan_valid = 1'b0, chan_last = 1'b0;
  logic [35:0] chan_data = '0;
  logic        chan_ready, word_stb, word_we;
  logic [17:0] word_addr;
  logic [35:0] word_data;
  logic [10:0] lba;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  xfer_addr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .da_we_i(da_we), .da_wdata_i(da_wdata), .da_o(da),
    .start_i(start), .op_i(op),
    .busy_o(busy), .done_o(done), .attn_o(attn), .err_o(err), .iae_o(iae),
    .last_sect_o(last_sect),
    .chan_valid_i(chan_valid), .chan_last_i(chan_last), .chan_data_i(chan_data),
    .chan_ready_o(chan_ready), .word_stb_o(word_stb), .word_we_o(word_we),
    .word_addr_o(word_addr), .word_data_o(word_data), .lba_o(lba)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_da(input logic [11:0] v);
    @(negedge clk); da_we = 1'b1; da_wdata = v;
    @(negedge clk); da_we = 1'b0;
  endtask

  task automatic start_op(input logic [1:0] o);
    @(negedge clk); start = 1'b1; op = o;
    @(negedge clk); start = 1'b0;
  endtask

  // Drives n words from (trk,sect); last flag on word n-1.
  task automatic run_words(input int trk, input int sect, input int n, input bit wr);
    for (int i = 0; i < n; i++) begin
      int s, t;
      chan_valid = 1'b1; chan_last = (i == n - 1); chan_data = 36'h5_0000_0000 + 36'(i);
      #1;
      s = sect + i / 128; t = trk + s / 64; s = s % 64;
      chk("R3", "word_stb", word_stb, 1);
      chk("R3", "word_addr", word_addr, (t * 64 + s) * 128 + i % 128);
      if (wr) chk("R7", "write data", word_data, 36'h5_0000_0000 + 36'(i));
      else    chk("R3", "read we", word_we, 0);
      @(posedge clk); @(negedge clk);
    end
    chan_valid = 1'b0; chan_last = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R1", "da after reset", da, 0);
    chk("R10", "busy after reset", busy, 0);
    chk("R10", "done after reset", done, 0);
    chk("R4", "flags after reset", {attn, err, iae, last_sect}, 0);
    chk("R4", "ready after reset", chan_ready, 0);
  endtask

  task automatic t_addr_reg;
    load_da(12'h083);
    chk("R1", "da readback", da, 16'h0083);
    chk("R3", "lba", lba, 2 * 64 + 3);
  endtask

  task automatic t_read_full;
    load_da(12'h0BF);
    start_op(2'd0);
    chk("R10", "busy after start", busy, 1);
    run_words(2, 63, 128, 1'b0);
    chk("R10", "done pulse", done, 1);
    chk("R10", "busy at done", busy, 0);
    chk("R5", "sector wraps to next track", da, 16'h00C0);
    @(negedge clk);
    chk("R10", "done one cycle", done, 0);
  endtask

  task automatic t_read_multi;
    load_da(12'h000);
    start_op(2'd0);
    run_words(0, 0, 130, 1'b0);
    chk("R5", "sector increment", da, 16'h0001);
    chk("R8", "partial read no advance", done, 1);
  endtask

  task automatic t_read_short_busy_load;
    load_da(12'h045);
    start_op(2'd0);
    load_da(12'h123);
    chk("R2", "load ignored while busy", da, 16'h0045);
    run_words(1, 5, 10, 1'b0);
    chk("R8", "short read address kept", da, 16'h0045);
    chk("R8", "short read done", done, 1);
  endtask

  task automatic t_write_short;
    int pads = 0;
    bit bad = 1'b0;
    load_da(12'h005);
    start_op(2'd1);
    run_words(0, 5, 3, 1'b1);
    for (int k = 0; k < 200 && !done; k++) begin
      if (!(word_stb && word_we && word_data == 0 && word_addr == 18'(5 * 128 + 3 + k))) bad = 1'b1;
      pads++;
      @(negedge clk);
    end
    chk("R7", "pad words zero and in sequence", bad, 0);
    chk("R7", "pad word count", pads, 125);
    chk("R7", "done after pad", done, 1);
    chk("R7", "address kept after pad", da, 16'h0005);
  endtask

  task automatic t_wrap_last;
    load_da(12'h7FF);
    start_op(2'd0);
    run_words(31, 63, 128, 1'b0);
    chk("R6", "last sector flag", last_sect, 1);
    chk("R5", "track stepped to 32", da, 16'h0800);
    start_op(2'd0);
    chk("R11", "start clears last flag", last_sect, 0);
    chan_valid = 1'b1; #1;
    chk("R4", "no ready on bad address", chan_ready, 0);
    chk("R4", "no strobe on bad address", word_stb, 0);
    @(negedge clk); chan_valid = 1'b0;
    chk("R4", "abort flags iae/err/attn", {iae, err, attn}, 3'b111);
    chk("R4", "abort clears busy", busy, 0);
    chk("R4", "abort no done", done, 0);
  endtask

  task automatic t_search;
    bit moved = 1'b0;
    load_da(12'hA00);
    start_op(2'd2);
    if (word_stb) moved = 1'b1;
    @(negedge clk);
    chk("R9", "bad search flags", {iae, err, attn}, 3'b111);
    chk("R9", "bad search idle", busy, 0);
    load_da(12'h123);
    start_op(2'd2);
    if (word_stb) moved = 1'b1;
    @(negedge clk);
    chk("R9", "good search attn only", {iae, err, attn}, 3'b001);
    chk("R9", "search no done", done, 0);
    chk("R9", "search no words", moved, 0);
  endtask

  task automatic t_rsvd_op;
    start_op(2'd3);
    chk("R11", "reserved op not busy", busy, 0);
    chk("R11", "reserved op keeps flags", attn, 1);
    @(negedge clk);
    chk("R11", "reserved op still idle", busy, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_ni = 1'b1;
    @(negedge clk);
    t_addr_reg();
    t_read_full();
    t_read_multi();
    t_read_short_busy_load();
    t_write_short();
    t_wrap_last();
    t_search();
    t_rsvd_op();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule